// File: doc/BRIEF.md
# Disk Controller Read Wait-State Generator

This block decides when a floppy disk controller card holds the processor in wait states. Software first arms a one-bit wait-enable flag through the card's single-bit output port. After that, a CPU read of one selected byte address in the controller window stalls the processor. The stall lasts until the controller signals that a byte is available (DRQ), raises its interrupt, or the drive motor stops turning. The stall works by enabling a buffer that pulls the shared READY line low. When the stall ends, the buffer goes back to high impedance and the line is not driven high.

A 16-bit CPU read reaches the card as two byte accesses, the odd byte first and the even byte second. Holding the odd access therefore also holds back the data-register read that follows it. A parameter moves the qualifying byte to the even address instead, for processors that only issue even-address byte reads. The pull-low request follows the access and the release inputs in the same cycle. Only the enable flag is a register.

Top module: `fdc_wait_gen`

## Requirements
- R1: After reset the wait-enable flag is clear, `rdy_oe` is 0 and `cpu_ready` is 1.
- R2: A clock edge with `bit_we`=1 and `bit_idx`=WAIT_BIT (default 2) loads `bit_val` into the wait-enable flag. Value 1 arms the wait and value 0 disarms it, both effective from the next cycle.
- R3: Bit-output writes to any other index leave the wait-enable flag unchanged.
- R4: `rdy_oe` is 1 in the same cycle exactly when all of these hold: the flag is armed, `ctl_sel_n`=0, the low three address bits equal the qualifying pattern, and `fdc_drq`=0, `fdc_irq`=0, `motor_on`=1. It stays 1 for as long as these hold.
- R5: With `ctl_sel_n`=1, `rdy_oe` is 0 whatever the other inputs are.
- R6: With ODD_ADDR=1 (default), the qualifying pattern is address bits [2:0]=3'b111 (byte 0x5FF7). An access at bits [2:0]=3'b110 (0x5FF6) never waits.
- R7: `fdc_drq`=1 drops `rdy_oe` to 0 in the same cycle.
- R8: `fdc_irq`=1 drops `rdy_oe` to 0 in the same cycle.
- R9: `motor_on`=0 (motor stopped) drops `rdy_oe` to 0 in the same cycle.
- R10: `cpu_ready` equals the inverse of `rdy_oe`, which is the level the READY line takes with its pull-up.
- R11: While the wait-enable flag is clear, `rdy_oe` stays 0 for every address and input pattern.
- R12: With ODD_ADDR=0, the qualifying pattern is bits [2:0]=3'b110 (0x5FF6), and bits 3'b111 never wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | ADDR_W | CPU byte address, bit 0 selects the odd byte |
| ctl_sel_n | input | 1 | Active-low decode of the controller address window |
| bit_we | input | 1 | Single-bit output write strobe |
| bit_idx | input | IDX_W | Single-bit output index |
| bit_val | input | 1 | Single-bit output value |
| fdc_irq | input | 1 | Controller interrupt request |
| fdc_drq | input | 1 | Controller data request (byte ready) |
| motor_on | input | 1 | Motor monostable output, 1 while the motor turns |
| rdy_oe | output | 1 | Enable of the buffer that pulls READY low |
| cpu_ready | output | 1 | Resolved READY level with pull-up (1 = ready) |

## Verification
Two functions can meet in the same clock edge. A write that disarms the wait-enable flag can land in the very cycle that DRQ ends a held access. The bench provokes this during a held odd-byte read: it raises DRQ and issues the disarming write together. It then judges that READY is released at once, and that it stays released after DRQ falls and the same odd address is presented again. A second case arms the flag in the same cycle as a qualifying access begins. There the pull-low request must appear only after the clock edge.

// File: rtl/fdc_wait_pkg.sv
package fdc_wait_pkg;

  // Number of low address bits that pick the qualifying byte
  localparam int unsigned QUAL_BITS = 3;

  // Release sources, each one ends a stall on its own
  typedef struct packed {
    logic drq;
    logic irq;
    logic motor_stopped;
  } release_t;

  // Qualifying low-address pattern: upper qualifier bits all ones,
  // bit 0 chooses odd or even byte
  function automatic logic [QUAL_BITS-1:0] qual_pattern(input bit odd);
    logic [QUAL_BITS-1:0] p;
    p = '1;
    p[0] = odd;
    return p;
  endfunction

endpackage

// File: rtl/fdc_wait_en_latch.sv
module fdc_wait_en_latch #(
  parameter int unsigned IDX_W    = 4,
  parameter int unsigned WAIT_BIT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_we,
  input  logic [IDX_W-1:0] bit_idx,
  input  logic             bit_val,
  output logic             en_q
);

  localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(WAIT_BIT);

  logic hit;
  assign hit = bit_we && (bit_idx == MY_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else if (hit) begin
      en_q <= bit_val;
    end
  end

endmodule

// File: rtl/fdc_wait_addr_qual.sv
module fdc_wait_addr_qual #(
  parameter int unsigned ADDR_W   = 16,
  parameter bit          ODD_ADDR = 1'b1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              sel_n,
  output logic              hit
);
  import fdc_wait_pkg::*;

  localparam logic [QUAL_BITS-1:0] PAT = qual_pattern(ODD_ADDR);

  logic [QUAL_BITS-1:0] bit_ok;

  // One comparator per qualifier bit, polarity from the pattern
  for (genvar i = 0; i < QUAL_BITS; i++) begin : g_bit
    if (PAT[i]) begin : g_one
      assign bit_ok[i] = addr[i];
    end else begin : g_zero
      assign bit_ok[i] = ~addr[i];
    end
  end

  assign hit = (~sel_n) & (&bit_ok);

endmodule

// File: rtl/fdc_wait_release.sv
module fdc_wait_release (
  input  logic fdc_drq,
  input  logic fdc_irq,
  input  logic motor_on,
  output logic hold
);
  import fdc_wait_pkg::*;

  release_t src;

  always_comb begin
    src.drq           = fdc_drq;
    src.irq           = fdc_irq;
    src.motor_stopped = ~motor_on;
  end

  // Stall may continue only while no release source is active
  assign hold = ~(|src);

endmodule

// File: rtl/fdc_wait_gen.sv
module fdc_wait_gen #(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned IDX_W    = 4,
  parameter int unsigned WAIT_BIT = 2,
  parameter bit          ODD_ADDR = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              ctl_sel_n,
  input  logic              bit_we,
  input  logic [IDX_W-1:0]  bit_idx,
  input  logic              bit_val,
  input  logic              fdc_irq,
  input  logic              fdc_drq,
  input  logic              motor_on,
  output logic              rdy_oe,
  output logic              cpu_ready
);

  logic wait_en;
  logic addr_hit;
  logic hold;

  fdc_wait_en_latch #(
    .IDX_W   (IDX_W),
    .WAIT_BIT(WAIT_BIT)
  ) u_en (
    .clk    (clk),
    .rst_n  (rst_n),
    .bit_we (bit_we),
    .bit_idx(bit_idx),
    .bit_val(bit_val),
    .en_q   (wait_en)
  );

  fdc_wait_addr_qual #(
    .ADDR_W  (ADDR_W),
    .ODD_ADDR(ODD_ADDR)
  ) u_qual (
    .addr (cpu_addr),
    .sel_n(ctl_sel_n),
    .hit  (addr_hit)
  );

  fdc_wait_release u_rel (
    .fdc_drq (fdc_drq),
    .fdc_irq (fdc_irq),
    .motor_on(motor_on),
    .hold    (hold)
  );

  // Buffer enable: every term of the OR into the buffer control must be low
  assign rdy_oe    = wait_en & addr_hit & hold;
  // Line level seen by the CPU with the pull-up when the buffer floats
  assign cpu_ready = ~rdy_oe;

endmodule

// File: rtl/fdc_wait_gen_checker.sv
module fdc_wait_gen_checker #(
  parameter int unsigned IDX_W    = 4,
  parameter int unsigned WAIT_BIT = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_sel_n,
  input logic             bit_we,
  input logic [IDX_W-1:0] bit_idx,
  input logic             bit_val,
  input logic             fdc_irq,
  input logic             fdc_drq,
  input logic             motor_on,
  input logic             wait_en,
  input logic             rdy_oe,
  input logic             cpu_ready
);

  localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(WAIT_BIT);

  p_load_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_we && bit_idx == MY_IDX) |=> (wait_en == $past(bit_val)));

  p_keep_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(bit_we && bit_idx == MY_IDX) |=> $stable(wait_en));

  p_no_select_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_sel_n |-> !rdy_oe);

  p_drq_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fdc_drq |-> !rdy_oe);

  p_irq_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fdc_irq |-> !rdy_oe);

  p_motor_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !motor_on |-> !rdy_oe);

  p_line_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready != rdy_oe);

  p_needs_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_oe |-> wait_en);

endmodule

bind fdc_wait_gen fdc_wait_gen_checker #(
  .IDX_W   (IDX_W),
  .WAIT_BIT(WAIT_BIT)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ctl_sel_n(ctl_sel_n),
  .bit_we   (bit_we),
  .bit_idx  (bit_idx),
  .bit_val  (bit_val),
  .fdc_irq  (fdc_irq),
  .fdc_drq  (fdc_drq),
  .motor_on (motor_on),
  .wait_en  (wait_en),
  .rdy_oe   (rdy_oe),
  .cpu_ready(cpu_ready)
);

// File: tb/fdc_wait_gen_bench.sv
module fdc_wait_gen_bench;

  localparam int unsigned ADDR_W = 16;
  localparam int unsigned IDX_W  = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] cpu_addr = 16'h0000;
  logic              ctl_sel_n = 1'b1;
  logic              bit_we = 1'b0;
  logic [IDX_W-1:0]  bit_idx = '0;
  logic              bit_val = 1'b0;
  logic              fdc_irq = 1'b0;
  logic              fdc_drq = 1'b0;
  logic              motor_on = 1'b1;
  logic              rdy_oe, cpu_ready;
  logic              ev_oe, ev_ready;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  fdc_wait_gen u_fdc_wait_gen (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .ctl_sel_n(ctl_sel_n),
    .bit_we(bit_we), .bit_idx(bit_idx), .bit_val(bit_val),
    .fdc_irq(fdc_irq), .fdc_drq(fdc_drq), .motor_on(motor_on),
    .rdy_oe(rdy_oe), .cpu_ready(cpu_ready)
  );

  fdc_wait_gen #(.ODD_ADDR(1'b0)) u_even (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .ctl_sel_n(ctl_sel_n),
    .bit_we(bit_we), .bit_idx(bit_idx), .bit_val(bit_val),
    .fdc_irq(fdc_irq), .fdc_drq(fdc_drq), .motor_on(motor_on),
    .rdy_oe(ev_oe), .cpu_ready(ev_ready)
  );

  task automatic check(input string req, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // drive at negedge, settle, then inspect combinational outputs
  task automatic settle();
    #1;
  endtask

  task automatic next_neg();
    @(negedge clk);
  endtask

  task automatic write_bit(input logic [IDX_W-1:0] idx, input logic v);
    next_neg();
    bit_we = 1'b1; bit_idx = idx; bit_val = v;
    next_neg();
    bit_we = 1'b0;
  endtask

  task automatic idle_bus();
    ctl_sel_n = 1'b1; cpu_addr = 16'h0000;
  endtask

  task automatic access(input logic [ADDR_W-1:0] a);
    ctl_sel_n = 1'b0; cpu_addr = a;
  endtask

  task automatic t_reset();
    settle();
    check("R1 oe in reset", rdy_oe, 1'b0);
    check("R1 ready in reset", cpu_ready, 1'b1);
    next_neg(); rst_n = 1'b1;
    access(16'h5FF7); settle();
    check("R1 flag clear after reset", rdy_oe, 1'b0);
    idle_bus();
  endtask

  task automatic t_flag_ctrl();
    write_bit(4'd2, 1'b1);
    access(16'h5FF7); settle();
    check("R2 armed wait", rdy_oe, 1'b1);
    check("R10 line low", cpu_ready, 1'b0);
    idle_bus();
    write_bit(4'd3, 1'b0);
    write_bit(4'd1, 1'b0);
    access(16'h5FF7); settle();
    check("R3 other index kept flag", rdy_oe, 1'b1);
    idle_bus();
    write_bit(4'd2, 1'b0);
    access(16'h5FF7); settle();
    check("R2 disarmed", rdy_oe, 1'b0);
    check("R10 line high", cpu_ready, 1'b1);
    idle_bus();
    write_bit(4'd5, 1'b1);
    access(16'h5FF7); settle();
    check("R3 other index no arm", rdy_oe, 1'b0);
    idle_bus();
  endtask

  // word read: odd byte held until DRQ, then even byte without wait
  task automatic t_word_read_drq();
    int held;
    write_bit(4'd2, 1'b1);
    access(16'h5FF7);
    held = 0;
    for (int i = 0; i < 6; i++) begin
      settle();
      if (rdy_oe) held++;
      next_neg();
    end
    tests++;
    if (held != 6) begin
      fails++;
      $display("FAIL R4: held %0d cycles expected 6", held);
    end
    fdc_drq = 1'b1; settle();
    check("R7 drq releases", rdy_oe, 1'b0);
    next_neg();
    access(16'h5FF6); settle();
    check("R6 even byte no wait", rdy_oe, 1'b0);
    fdc_drq = 1'b0; settle();
    check("R6 even byte no wait drq low", rdy_oe, 1'b0);
    idle_bus();
  endtask

  task automatic t_irq_motor();
    next_neg(); access(16'h5FF7); settle();
    check("R4 held again", rdy_oe, 1'b1);
    fdc_irq = 1'b1; settle();
    check("R8 irq releases", rdy_oe, 1'b0);
    fdc_irq = 1'b0; settle();
    check("R4 irq gone holds", rdy_oe, 1'b1);
    motor_on = 1'b0; settle();
    check("R9 motor stop releases", rdy_oe, 1'b0);
    check("R10 line follows", cpu_ready, 1'b1);
    motor_on = 1'b1;
    idle_bus();
  endtask

  task automatic t_select_addr();
    next_neg();
    ctl_sel_n = 1'b1; cpu_addr = 16'h5FF7; settle();
    check("R5 not selected", rdy_oe, 1'b0);
    access(16'h5FF3); settle();
    check("R4 other low bits", rdy_oe, 1'b0);
    access(16'h5FF5); settle();
    check("R4 bit1 clear", rdy_oe, 1'b0);
    access(16'h1237); settle();
    check("R4 low bits only qualify", rdy_oe, 1'b1);
    idle_bus();
  endtask

  task automatic t_even_variant();
    next_neg(); access(16'h5FF6); settle();
    check("R12 even variant waits 6", ev_oe, 1'b1);
    check("R12 even variant ready low", ev_ready, 1'b0);
    access(16'h5FF7); settle();
    check("R12 even variant ignores 7", ev_oe, 1'b0);
    fdc_drq = 1'b1; access(16'h5FF6); settle();
    check("R12 even variant drq release", ev_oe, 1'b0);
    fdc_drq = 1'b0;
    idle_bus();
  endtask

  // disarm write and DRQ in the same cycle of a held access
  task automatic t_same_cycle();
    next_neg(); access(16'h5FF7); settle();
    check("R4 held before collision", rdy_oe, 1'b1);
    next_neg();
    fdc_drq = 1'b1; bit_we = 1'b1; bit_idx = 4'd2; bit_val = 1'b0; settle();
    check("R7 release in collision", rdy_oe, 1'b0);
    next_neg();
    bit_we = 1'b0; fdc_drq = 1'b0; settle();
    check("R11 stays released after disarm", rdy_oe, 1'b0);
    // arm in same cycle as access begins: effect only after the edge
    next_neg();
    bit_we = 1'b1; bit_idx = 4'd2; bit_val = 1'b1; settle();
    check("R11 no wait before arm edge", rdy_oe, 1'b0);
    next_neg(); bit_we = 1'b0; settle();
    check("R2 wait after arm edge", rdy_oe, 1'b1);
    idle_bus();
  endtask

  task automatic t_disabled_sweep();
    write_bit(4'd2, 1'b0);
    for (int a = 0; a < 16; a++) begin
      access(16'h5FF0 + 16'(a)); settle();
      check("R11 disabled sweep", rdy_oe, 1'b0);
      check("R11 disabled sweep even", ev_oe, 1'b0);
    end
    idle_bus();
  endtask

  initial begin
    t_reset();
    t_flag_ctrl();
    t_word_read_drq();
    t_irq_motor();
    t_select_addr();
    t_even_variant();
    t_same_cycle();
    t_disabled_sweep();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: run did not end, got timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule